// File: doc/BRIEF.md
# FPU Context Save/Restore Engine

This block moves the floating-point unit's internal context to and from memory as a frame. A save request writes a frame starting from an address-register value. The frame is a single zero word when the unit has just been reset. Otherwise it is a seven-word idle frame, written in ascending order (postincrement or plain indirect) or in descending order (predecrement). When the address mode calls for it, the engine returns the updated address-register value.

A restore request reads one header word. A header whose top byte is zero is a null frame. It pulses a clear of the control, status and instruction-address registers, then writes a NaN pattern into all eight FP registers, one per cycle, and marks the unit as just reset. A non-null header selects the postincrement adjustment from its type byte and clears the just-reset mark. The mark is also cleared by any arithmetic or move instruction, which the core signals with a one-cycle `arith_op` pulse.

Top module: `fpu_ctx_unit`

## Requirements
- R1: After reset the engine is idle (`busy`=0), `jr_flag`=1, and neither `mem_req` nor `fpr_we` is asserted. Bus accesses and FP register writes never occur in the same cycle.
- R2: A save started while `jr_flag`=1 writes exactly one word of value 0. With `am`=01 (postincrement) it goes to A and the new address is A+4. With `am`=10 (predecrement) it goes to A-4 and the new address is A-4.
- R3: A save with `jr_flag`=0 and `am`=01 writes seven words, one per cycle, at A, A+4, … A+24. The word at A is 0x1F180000, the word at A+24 is 0x70000000 and the five between are 0. The new address is A+28.
- R4: The same save with `am`=10 writes 0x70000000 at A-4 first, then zeros in descending order, and 0x1F180000 last at A-28. The new address is A-28.
- R5: A restore reads one word at A. If bits 31:24 are zero, `ctl_clr` pulses for one cycle. The next eight cycles then write FP registers 0 to 7 in order, each with {16'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF}. `jr_flag` becomes 1, and with `am`=01 the new address is A+4.
- R6: A non-null restore with `am`=01 returns A+4+24, A+4+56 or A+4+180 for header bits 23:16 equal to 0x18, 0x38 or 0xB4. It also clears `jr_flag`.
- R7: A non-null header with any other type byte raises `err` together with `done`, and returns A+4.
- R8: With `am`=00, or `am`=11 (treated as 00), a save writes in ascending order and a restore reads at A. In both cases `areg_we` stays low at `done`, so the address register is not modified. A restore with `am`=10 also behaves as this mode.
- R9: `arith_op` clears `jr_flag`. If it arrives in the cycle in which a null restore completes, the completion wins and `jr_flag` ends at 1.
- R10: Start requests while `busy` is high are ignored. When `start_save` and `start_restore` arrive together, only the save runs.
- R11: `done` pulses for exactly one cycle, in the cycle after the last bus access or the last FP register write. `areg_out`/`areg_we` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_save | input | 1 | Begin a context save |
| start_restore | input | 1 | Begin a context restore |
| am | input | 2 | Address mode: 00 indirect, 01 postincrement, 10 predecrement |
| areg_in | input | 32 | Address-register value at start |
| arith_op | input | 1 | An FP arithmetic or move instruction executed |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| fpr_we | output | 1 | FP register write strobe |
| fpr_idx | output | 3 | FP register index |
| fpr_data | output | 80 | FP register write value |
| ctl_clr | output | 1 | Clear control, status and instruction-address registers |
| areg_out | output | 32 | Updated address-register value |
| areg_we | output | 1 | Load `areg_out` into the address register |
| done | output | 1 | Operation complete |
| err | output | 1 | Unrecognised frame type |
| busy | output | 1 | Operation in progress |
| jr_flag | output | 1 | Just-reset mark |

## Verification
Two functions can act on the just-reset mark in the same cycle: completion of a null restore sets it, and the `arith_op` pulse clears it. The bench watches for the write to FP register 7 and raises `arith_op` in that exact cycle, then expects `jr_flag` at 1. A following lone pulse is expected to clear it. A second collision is also provoked. A save request is raised while a restore is still filling registers, and `start_save` and `start_restore` are raised in the same cycle. The scoreboard then rejects any bus access it did not queue.

// File: rtl/fpu_ctx_unit.sv
module fpu_ctx_unit #(
  parameter int NUM_FPR    = 8,
  parameter int IDLE_WORDS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_save,
  input  logic        start_restore,
  input  logic [1:0]  am,
  input  logic [31:0] areg_in,
  input  logic        arith_op,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        fpr_we,
  output logic [2:0]  fpr_idx,
  output logic [79:0] fpr_data,
  output logic        ctl_clr,
  output logic [31:0] areg_out,
  output logic        areg_we,
  output logic        done,
  output logic        err,
  output logic        busy,
  output logic        jr_flag
);
  localparam int BW = $clog2(IDLE_WORDS);
  localparam int IW = $clog2(NUM_FPR);
  localparam int CW = (BW > IW) ? BW : IW;
  localparam logic [31:0] HDR_WORD  = 32'h1F18_0000;
  localparam logic [31:0] TAIL_WORD = 32'h7000_0000;
  localparam logic [79:0] NAN_VAL   = {16'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF};

  typedef enum logic [2:0] {S_IDLE, S_SAVE, S_RD, S_RDW, S_FILL} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [31:0] base;
  logic [1:0]  mode;
  logic        null_sv;

  wire is_pre = (mode == 2'b10);
  wire is_inc = (mode == 2'b01);
  wire [CW-1:0] last_beat = null_sv ? '0 : CW'(IDLE_WORDS - 1);
  wire [31:0] beat_off = 32'(cnt) << 2;
  wire [31:0] frame_len = (32'(last_beat) + 32'd1) << 2;
  wire [31:0] save_addr = is_pre ? (base - beat_off - 32'd4) : (base + beat_off);

  logic [31:0] save_data;
  always_comb begin
    if (null_sv)                save_data = '0;
    else if (cnt == '0)         save_data = is_pre ? TAIL_WORD : HDR_WORD;
    else if (cnt == last_beat)  save_data = is_pre ? HDR_WORD : TAIL_WORD;
    else                        save_data = '0;
  end

  wire hdr_null = (mem_rdata[31:24] == 8'h00);
  logic [31:0] hdr_adj;
  logic        hdr_bad;
  always_comb begin
    hdr_bad = 1'b0;
    case (mem_rdata[23:16])
      8'h18:   hdr_adj = 32'd24;
      8'h38:   hdr_adj = 32'd56;
      8'hB4:   hdr_adj = 32'd180;
      default: begin hdr_adj = 32'd0; hdr_bad = 1'b1; end
    endcase
  end
  logic unused_lo;
  assign unused_lo = ^mem_rdata[15:0];

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_SAVE) || (st == S_RD);
  assign mem_we    = (st == S_SAVE);
  assign mem_addr  = (st == S_RD) ? base : save_addr;
  assign mem_wdata = (st == S_SAVE) ? save_data : '0;
  assign ctl_clr   = (st == S_RDW) && hdr_null;
  assign fpr_we    = (st == S_FILL);
  assign fpr_idx   = 3'(cnt);
  assign fpr_data  = NAN_VAL;

  wire fill_last = (st == S_FILL) && (cnt == CW'(NUM_FPR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; base <= '0; mode <= '0; null_sv <= 1'b0;
      done <= 1'b0; err <= 1'b0; areg_we <= 1'b0; areg_out <= '0;
    end else begin
      done <= 1'b0; err <= 1'b0; areg_we <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start_save) begin
            st <= S_SAVE; base <= areg_in; mode <= am; null_sv <= jr_flag;
          end else if (start_restore) begin
            st <= S_RD; base <= areg_in; mode <= am; null_sv <= 1'b0;
          end
        end
        S_SAVE: begin
          if (cnt == last_beat) begin
            st <= S_IDLE; done <= 1'b1;
            areg_we  <= is_pre || is_inc;
            areg_out <= is_pre ? (base - frame_len) : (base + frame_len);
          end else cnt <= cnt + 1'b1;
        end
        S_RD: st <= S_RDW;
        S_RDW: begin
          if (hdr_null) begin
            st <= S_FILL; cnt <= '0;
          end else begin
            st <= S_IDLE; done <= 1'b1; err <= hdr_bad;
            areg_we  <= is_inc;
            areg_out <= base + 32'd4 + hdr_adj;
          end
        end
        S_FILL: begin
          if (fill_last) begin
            st <= S_IDLE; done <= 1'b1;
            areg_we  <= is_inc;
            areg_out <= base + 32'd4;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            jr_flag <= 1'b1;
    else if (fill_last)                    jr_flag <= 1'b1;
    else if ((st == S_RDW) && !hdr_null)   jr_flag <= 1'b0;
    else if (arith_op)                     jr_flag <= 1'b0;
  end

  a_r1_bus_fpr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && fpr_we));
  a_r3_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we)) |->
      (mem_addr == $past(mem_addr) + 32'd4 || mem_addr == $past(mem_addr) - 32'd4));
  a_r5_fill_follows_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_clr) |=> (fpr_we && fpr_idx == 3'd0));
  a_r9_null_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fpr_we && fpr_idx == 3'(NUM_FPR - 1)) |=> (done && jr_flag));
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r10_save_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_save && !busy) |=> (mem_req && mem_we));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_fpu_ctx_unit.sv
module test_fpu_ctx_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_save = 0, start_restore = 0, arith_op = 0;
  logic [1:0] am = 0;
  logic [31:0] areg_in = 0, mem_rdata = 0, hdr_word = 0;
  logic mem_req, mem_we, fpr_we, ctl_clr, areg_we, done, err, busy, jr_flag;
  logic [31:0] mem_addr, mem_wdata, areg_out;
  logic [2:0] fpr_idx;
  logic [79:0] fpr_data;
  int checks = 0, errors = 0, fpr_exp = 0;
  logic [64:0] exp_q[$];

  always #2 clk = ~clk;

  fpu_ctx_unit i_fpu_ctx_unit (.*);

  always @(posedge clk) mem_rdata <= (mem_req && !mem_we) ? hdr_word : 32'hDEAD_BEEF;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected bus access", mem_addr, 32'hFFFF_FFFF);
      else begin
        logic [64:0] e;
        e = exp_q.pop_front();
        chk(mem_we == e[64], "R3 access direction", 32'(mem_we), 32'(e[64]));
        chk(mem_addr == e[63:32], "R4 access address", mem_addr, e[63:32]);
        if (e[64]) chk(mem_wdata == e[31:0], "R3 write data", mem_wdata, e[31:0]);
      end
    end
    if (rst_n && fpr_we) begin
      chk(fpr_idx == 3'(fpr_exp), "R5 fpr index", 32'(fpr_idx), fpr_exp);
      chk(fpr_data == {16'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF}, "R5 fpr data", fpr_data[79:48], 32'h7FFF_FFFF);
      fpr_exp++;
    end
  end

  task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back({we, a, d});
  endtask

  task automatic run_op(input bit sv, input bit rs, input logic [1:0] m, input logic [31:0] a,
                        input bit poke, input bit hit, output int clr_n, output bit prev_req);
    @(negedge clk);
    am = m; areg_in = a; start_save = sv; start_restore = rs;
    @(negedge clk);
    start_save = 0; start_restore = 0;
    clr_n = 0; prev_req = 0;
    while (!done) begin
      if (poke) begin start_save = 1; start_restore = 1; poke = 0; end
      else begin start_save = 0; start_restore = 0; end
      arith_op = (hit && fpr_we && fpr_idx == 3'd7);
      if (ctl_clr) clr_n++;
      prev_req = mem_req;
      @(negedge clk);
    end
    start_save = 0; start_restore = 0; arith_op = 0;
  endtask

  task automatic do_save(input logic [1:0] m, input logic [31:0] a, input bit nul,
                         input logic [31:0] ea, input bit ewe);
    int c; bit pr;
    if (nul) push(1, (m == 2'b10) ? a - 4 : a, 0);
    else for (int i = 0; i < 7; i++) begin
      logic [31:0] d;
      d = (i == 0) ? ((m == 2'b10) ? 32'h7000_0000 : 32'h1F18_0000) :
          (i == 6) ? ((m == 2'b10) ? 32'h1F18_0000 : 32'h7000_0000) : 0;
      push(1, (m == 2'b10) ? a - 4 - 4*i : a + 4*i, d);
    end
    run_op(1, 0, m, a, 0, 0, c, pr);
    chk(pr, "R11 done one cycle after last write", 32'(pr), 1);
    chk(areg_we == ewe, "R8 save address write enable", 32'(areg_we), 32'(ewe));
    if (ewe) chk(areg_out == ea, "R2 R3 R4 save new address", areg_out, ea);
    chk(exp_q.size() == 0, "R3 all frame words written", exp_q.size(), 0);
  endtask

  task automatic do_restore(input logic [1:0] m, input logic [31:0] a, input logic [31:0] h,
                            input logic [31:0] ea, input bit ewe, input bit eerr, input bit poke, input bit hit);
    int c; bit pr;
    hdr_word = h; fpr_exp = 0;
    push(0, a, 0);
    run_op(0, 1, m, a, poke, hit, c, pr);
    chk(err == eerr, "R7 error flag", 32'(err), 32'(eerr));
    chk(areg_we == ewe, "R8 restore address write enable", 32'(areg_we), 32'(ewe));
    if (ewe) chk(areg_out == ea, "R6 restore new address", areg_out, ea);
    chk(c == ((h[31:24] == 0) ? 1 : 0), "R5 control clear pulse count", c, (h[31:24] == 0) ? 1 : 0);
    chk(fpr_exp == ((h[31:24] == 0) ? 8 : 0), "R5 fpr write count", fpr_exp, (h[31:24] == 0) ? 8 : 0);
    chk(exp_q.size() == 0, "R10 no extra access", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset", 32'(busy), 0);
    chk(jr_flag, "R1 just-reset flag after reset", 32'(jr_flag), 1);
    chk(!mem_req && !fpr_we, "R1 no activity after reset", 32'(mem_req), 0);
    do_save(2'b01, 32'h1000, 1, 32'h1004, 1);
    @(negedge clk); arith_op = 1; @(negedge clk); arith_op = 0;
    chk(!jr_flag, "R9 arith_op clears flag", 32'(jr_flag), 0);
    do_save(2'b01, 32'h1000, 0, 32'h101C, 1);
    do_save(2'b10, 32'h2000, 0, 32'h1FE4, 1);
    do_save(2'b00, 32'h3000, 0, 0, 0);
    do_restore(2'b01, 32'h4000, 32'h1F18_0000, 32'h401C, 1, 0, 0, 0);
    do_restore(2'b01, 32'h4000, 32'h4138_0000, 32'h403C, 1, 0, 0, 0);
    do_restore(2'b01, 32'h4000, 32'h41B4_0000, 32'h40B8, 1, 0, 0, 0);
    do_restore(2'b01, 32'h4000, 32'h4155_0000, 32'h4004, 1, 1, 0, 0);
    do_restore(2'b00, 32'h4800, 32'h1F18_0000, 0, 0, 0, 0, 0);
    do_restore(2'b01, 32'h5000, 32'h0000_0000, 32'h5004, 1, 0, 1, 0);
    chk(jr_flag, "R5 null restore sets flag", 32'(jr_flag), 1);
    do_save(2'b10, 32'h6000, 1, 32'h5FFC, 1);
    do_restore(2'b01, 32'h4000, 32'h1F18_0000, 32'h401C, 1, 0, 0, 0);
    chk(!jr_flag, "R6 non-null restore clears flag", 32'(jr_flag), 0);
    do_restore(2'b01, 32'h7000, 32'h0000_0000, 32'h7004, 1, 0, 0, 1);
    chk(jr_flag, "R9 null completion wins over arith_op", 32'(jr_flag), 1);
    @(negedge clk); arith_op = 1; @(negedge clk); arith_op = 0;
    chk(!jr_flag, "R9 lone arith_op clears flag", 32'(jr_flag), 0);
    for (int i = 0; i < 7; i++)
      push(1, 32'h8000 + 4*i, (i == 0) ? 32'h1F18_0000 : (i == 6) ? 32'h7000_0000 : 0);
    begin
      int c; bit pr;
      run_op(1, 1, 2'b01, 32'h8000, 0, 0, c, pr);
      chk(areg_out == 32'h801C, "R10 save wins simultaneous start", areg_out, 32'h801C);
      chk(exp_q.size() == 0, "R10 save frame complete", exp_q.size(), 0);
    end
    repeat (4) @(negedge clk);
    chk(!busy, "R10 no restore after simultaneous start", 32'(busy), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule